// File: doc/BRIEF.md
# Shift-Right and Negate Unit with Status Update

This block is an 8-bit execution slice that handles two single-operand instructions of a small microcontroller core: a logical shift right by one, and the two's-complement negation. Each cycle it takes the 16-bit instruction word, the value read from the destination register and the current 8-bit status byte. One clock later it presents the result byte, the destination register index taken from the instruction word and a new status byte. In that byte only the flags the instruction defines are rewritten. Every other bit is copied from the input.

The status byte uses a fixed layout that the surrounding core decodes: bit 0 carry (C), bit 1 zero (Z), bit 2 negative (N), bit 3 overflow (V), bit 4 sign (S), bit 5 half-carry (H), bit 6 transfer bit (T), bit 7 interrupt enable (I). Any instruction word that matches neither pattern, or any cycle where the input is not marked valid, gives a result equal to the operand, a status equal to the input status and a low output valid. The fetch logic, the register file and every other instruction are handled elsewhere.

Top module: `shalu_core`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `result`, `status_out` and `out_dest` all become zero.
- R2: The shift-right instruction is recognised when `(opcode & 16'hFE0F) == 16'h9406`. Negate is recognised when `(opcode & 16'hFE0F) == 16'h9401`. For either one, `out_dest` carries `opcode[8:4]` and `out_valid` is high.
- R3: Shift right gives `operand >> 1`, with a zero shifted into bit 7.
- R4: Shift right sets C (bit 0) to operand bit 0, clears N (bit 2) and sets Z (bit 1) when the result is zero. It sets V (bit 3) to N xor C and S (bit 4) to N xor V, both from the new N and C. H (bit 5) is left unchanged.
- R5: Negate gives `(0 - operand) mod 256`.
- R6: Negate sets Z when the result is zero and N to result bit 7. It sets V only when the result is 0x80, C whenever the result is nonzero, and H to result bit 3 OR operand bit 3.
- R7: T (bit 6) and I (bit 7) of `status_out` always equal the matching bits of `status_in` from the cycle before.
- R8: With `in_valid` low, or with an instruction word that matches neither pattern, `out_valid` is low, `status_out` equals `status_in` and `result` equals `operand`, all from the cycle before.
- R9: Outputs appear exactly one clock after the inputs are sampled. A new instruction may be presented every cycle.
- R10: For both instructions, S equals N xor V in the produced status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Inputs on this cycle are meaningful |
| opcode | input | 16 | Instruction word |
| operand | input | 8 | Destination register value before the operation |
| status_in | input | 8 | Current status byte |
| out_valid | output | 1 | Registered: a supported instruction was executed |
| result | output | 8 | Registered result byte |
| status_out | output | 8 | Registered updated status byte |
| out_dest | output | 5 | Registered destination register index |

## Verification
Negating zero is the main trap: a design that sets carry from the operand, or always sets it, reports a borrow with Z also set. Negating 0x80 must give 0x80 with V and N set and S clear; a design that forms V from the sign bit alone, or S from N alone, gets S wrong here. Shifting 0x01 must raise Z and C together and give V and S equal to C, and an H or T/I bit that is set on entry must come out unchanged. Instruction words that differ from a valid pattern in one masked bit must be passed through with out_valid low, which catches a mask that is too loose.

// File: rtl/shalu_pkg.sv
package shalu_pkg;

  localparam int STAT_W = 8;

  localparam int FLG_C = 0;
  localparam int FLG_Z = 1;
  localparam int FLG_N = 2;
  localparam int FLG_V = 3;
  localparam int FLG_S = 4;
  localparam int FLG_H = 5;
  localparam int FLG_T = 6;
  localparam int FLG_I = 7;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_LSR  = 2'd1,
    OP_NEG  = 2'd2
  } op_kind_e;

  typedef struct packed {
    logic h;
    logic s;
    logic v;
    logic n;
    logic z;
    logic c;
  } flags_t;

endpackage

// File: rtl/shalu_decode.sv
module shalu_decode
  import shalu_pkg::*;
#(
  parameter int              OPC_W   = 16,
  parameter logic [OPC_W-1:0] OPC_MASK = 16'hFE0F,
  parameter logic [OPC_W-1:0] LSR_PAT  = 16'h9406,
  parameter logic [OPC_W-1:0] NEG_PAT  = 16'h9401,
  parameter int              DST_LSB = 4,
  parameter int              DST_W   = 5
) (
  input  logic             valid_i,
  input  logic [OPC_W-1:0] opcode_i,
  output op_kind_e         kind_o,
  output logic [DST_W-1:0] dest_o
);

  localparam int DST_MSB = DST_LSB + DST_W - 1;

  logic [OPC_W-1:0] masked;
  logic             is_lsr;
  logic             is_neg;

  assign masked = opcode_i & OPC_MASK;
  assign is_lsr = (masked == LSR_PAT);
  assign is_neg = (masked == NEG_PAT);
  assign dest_o = opcode_i[DST_MSB:DST_LSB];

  always_comb begin
    kind_o = OP_NONE;
    if (valid_i) begin
      if (is_lsr)      kind_o = OP_LSR;
      else if (is_neg) kind_o = OP_NEG;
    end
  end

endmodule

// File: rtl/shalu_lsr.sv
module shalu_lsr
  import shalu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  output logic [DATA_W-1:0] res_o,
  output flags_t            flg_o
);

  always_comb begin
    res_o     = {1'b0, a_i[DATA_W-1:1]};
    flg_o.c   = a_i[0];
    flg_o.n   = 1'b0;
    flg_o.z   = (res_o == '0);
    flg_o.v   = flg_o.n ^ flg_o.c;
    flg_o.s   = flg_o.n ^ flg_o.v;
    flg_o.h   = 1'b0;
  end

endmodule

// File: rtl/shalu_neg.sv
module shalu_neg
  import shalu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int HALF_BIT = 3
) (
  input  logic [DATA_W-1:0] a_i,
  output logic [DATA_W-1:0] res_o,
  output flags_t            flg_o
);

  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};

  always_comb begin
    res_o   = '0 - a_i;
    flg_o.z = (res_o == '0);
    flg_o.n = res_o[DATA_W-1];
    flg_o.v = (res_o == MOST_NEG);
    flg_o.s = flg_o.n ^ flg_o.v;
    flg_o.c = (res_o != '0);
    flg_o.h = res_o[HALF_BIT] | a_i[HALF_BIT];
  end

endmodule

// File: rtl/shalu_core.sv
module shalu_core
  import shalu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OPC_W  = 16,
  parameter int DST_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [DATA_W-1:0] operand,
  input  logic [STAT_W-1:0] status_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] result,
  output logic [STAT_W-1:0] status_out,
  output logic [DST_W-1:0]  out_dest
);

  op_kind_e          kind;
  op_kind_e          kind_q;
  logic [DST_W-1:0]  dest;
  logic [DATA_W-1:0] lsr_res;
  logic [DATA_W-1:0] neg_res;
  flags_t            lsr_flg;
  flags_t            neg_flg;
  logic [DATA_W-1:0] res_nxt;
  logic [STAT_W-1:0] stat_nxt;
  logic              armed;

  shalu_decode #(
    .OPC_W (OPC_W),
    .DST_W (DST_W)
  ) u_dec (
    .valid_i  (in_valid),
    .opcode_i (opcode),
    .kind_o   (kind),
    .dest_o   (dest)
  );

  shalu_lsr #(.DATA_W(DATA_W)) u_lsr (
    .a_i   (operand),
    .res_o (lsr_res),
    .flg_o (lsr_flg)
  );

  shalu_neg #(.DATA_W(DATA_W)) u_neg (
    .a_i   (operand),
    .res_o (neg_res),
    .flg_o (neg_flg)
  );

  // Merge: untouched flags fall through from status_in.
  always_comb begin
    res_nxt  = operand;
    stat_nxt = status_in;
    unique case (kind)
      OP_LSR: begin
        res_nxt         = lsr_res;
        stat_nxt[FLG_C] = lsr_flg.c;
        stat_nxt[FLG_Z] = lsr_flg.z;
        stat_nxt[FLG_N] = lsr_flg.n;
        stat_nxt[FLG_V] = lsr_flg.v;
        stat_nxt[FLG_S] = lsr_flg.s;
      end
      OP_NEG: begin
        res_nxt         = neg_res;
        stat_nxt[FLG_C] = neg_flg.c;
        stat_nxt[FLG_Z] = neg_flg.z;
        stat_nxt[FLG_N] = neg_flg.n;
        stat_nxt[FLG_V] = neg_flg.v;
        stat_nxt[FLG_S] = neg_flg.s;
        stat_nxt[FLG_H] = neg_flg.h;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      result     <= '0;
      status_out <= '0;
      out_dest   <= '0;
      kind_q     <= OP_NONE;
      armed      <= 1'b0;
    end else begin
      out_valid  <= (kind != OP_NONE);
      result     <= res_nxt;
      status_out <= stat_nxt;
      out_dest   <= dest;
      kind_q     <= kind;
      armed      <= 1'b1;
    end
  end

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
    armed && !out_valid |-> status_out == $past(status_in) && result == $past(operand)); // R8

  AST_KEEP_TI: assert property (@(posedge clk) disable iff (rst)
    armed |-> status_out[FLG_I:FLG_T] == $past(status_in[FLG_I:FLG_T])); // R7

  AST_SIGN_XOR: assert property (@(posedge clk) disable iff (rst)
    armed && out_valid |-> status_out[FLG_S] == (status_out[FLG_N] ^ status_out[FLG_V])); // R10

  AST_LSR_TOP: assert property (@(posedge clk) disable iff (rst)
    armed && kind_q == OP_LSR |-> !result[DATA_W-1] && !status_out[FLG_N]
                                  && status_out[FLG_H] == $past(status_in[FLG_H])); // R4

  AST_NEG_CARRY: assert property (@(posedge clk) disable iff (rst)
    armed && kind_q == OP_NEG |-> status_out[FLG_C] == (result != '0)); // R6

  AST_VALID_LAT: assert property (@(posedge clk) disable iff (rst)
    armed |-> out_valid == ($past(in_valid) && ($past(opcode[3:0]) == 4'h6 || $past(opcode[3:0]) == 4'h1)
                            && $past(opcode[15:9]) == 7'b1001010)); // R9

endmodule

// File: tb/tb_shalu_core.sv
module tb_shalu_core;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [15:0] opcode;
  logic [7:0]  operand;
  logic [7:0]  status_in;
  logic        out_valid;
  logic [7:0]  result;
  logic [7:0]  status_out;
  logic [4:0]  out_dest;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  shalu_core dut (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .opcode     (opcode),
    .operand    (operand),
    .status_in  (status_in),
    .out_valid  (out_valid),
    .result     (result),
    .status_out (status_out),
    .out_dest   (out_dest)
  );

  // Reference per requirements: neg=0 shift right, neg=1 negate.
  function automatic logic [7:0] m_res(bit neg, logic [7:0] a);
    if (neg) return 8'(9'h100 - {1'b0, a});
    return {1'b0, a[7:1]};
  endfunction

  function automatic logic [7:0] m_stat(bit neg, logic [7:0] a, logic [7:0] st);
    logic [7:0] r;
    logic [7:0] s;
    r = m_res(neg, a);
    s = st;
    if (neg) begin
      s[1] = (r == 8'h00);
      s[2] = r[7];
      s[3] = (r == 8'h80);
      s[4] = s[2] ^ s[3];
      s[0] = (r != 8'h00);
      s[5] = r[3] | a[3];
    end else begin
      s[0] = a[0];
      s[2] = 1'b0;
      s[1] = (r == 8'h00);
      s[3] = s[0];
      s[4] = s[0];
    end
    return s;
  endfunction

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(logic v, logic [15:0] opc, logic [7:0] a, logic [7:0] st);
    in_valid  = v;
    opcode    = opc;
    operand   = a;
    status_in = st;
  endtask

  // One operation: drive at negedge, sample at the next negedge.
  task automatic one_op(string req, logic v, logic [15:0] opc, logic [7:0] a,
                        logic [7:0] st, bit hit, bit neg);
    @(negedge clk);
    drive(v, opc, a, st);
    @(negedge clk);
    chk(req, "valid", {15'd0, out_valid}, {15'd0, hit});
    if (hit) begin
      chk(req, "result", {8'd0, result}, {8'd0, m_res(neg, a)});
      chk(req, "status", {8'd0, status_out}, {8'd0, m_stat(neg, a, st)});
      chk(req, "dest", {11'd0, out_dest}, {11'd0, opc[8:4]});
    end else begin
      chk(req, "result", {8'd0, result}, {8'd0, a});
      chk(req, "status", {8'd0, status_out}, {8'd0, st});
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst = 1'b1;
    drive(1'b1, 16'h9406, 8'hFF, 8'hFF);
    @(negedge clk);
    @(negedge clk);
    chk("R1", "valid", {15'd0, out_valid}, 16'd0);
    chk("R1", "result", {8'd0, result}, 16'd0);
    chk("R1", "status", {8'd0, status_out}, 16'd0);
    chk("R1", "dest", {11'd0, out_dest}, 16'd0);
    rst = 1'b0;
    drive(1'b0, 16'h0000, 8'h00, 8'h00);
  endtask

  task automatic t_lsr_known();
    one_op("R3", 1'b1, 16'h9476, 8'h45, 8'h00, 1'b1, 1'b0);
    chk("R4", "status 0x19", {8'd0, status_out}, 16'h0019);
    chk("R3", "result 0x22", {8'd0, result}, 16'h0022);
  endtask

  task automatic t_lsr_zero();
    one_op("R4", 1'b1, 16'h9406, 8'h01, 8'h04, 1'b1, 1'b0);
    chk("R4", "Z,C,V,S set N clear", {8'd0, status_out}, 16'h001B);
  endtask

  task automatic t_lsr_keep_h();
    one_op("R7", 1'b1, 16'h95F6, 8'hFE, 8'hE0, 1'b1, 1'b0);
    chk("R4", "H kept", {15'd0, status_out[5]}, 16'd1);
    chk("R2", "dest 31", {11'd0, out_dest}, 16'd31);
  endtask

  task automatic t_neg_known();
    one_op("R5", 1'b1, 16'h9541, 8'h56, 8'h00, 1'b1, 1'b1);
    chk("R5", "result 0xAA", {8'd0, result}, 16'h00AA);
    chk("R6", "status 0x35", {8'd0, status_out}, 16'h0035);
  endtask

  task automatic t_neg_zero();
    one_op("R6", 1'b1, 16'h9401, 8'h00, 8'hDF, 1'b1, 1'b1);
    chk("R6", "neg 0 status", {8'd0, status_out}, 16'h00C2);
  endtask

  task automatic t_neg_min();
    one_op("R6", 1'b1, 16'h9401, 8'h80, 8'h00, 1'b1, 1'b1);
    chk("R10", "neg 0x80 status", {8'd0, status_out}, 16'h000D);
  endtask

  task automatic t_unsupported();
    one_op("R8", 1'b1, 16'h9402, 8'h33, 8'h5A, 1'b0, 1'b0);
    one_op("R8", 1'b1, 16'h9606, 8'h33, 8'hA5, 1'b0, 1'b0);
    one_op("R8", 1'b1, 16'h9416, 8'h10, 8'h3C, 1'b1, 1'b0);
    one_op("R8", 1'b0, 16'h9401, 8'h77, 8'h81, 1'b0, 1'b1);
  endtask

  // Stream every operand, alternating instructions each cycle.
  task automatic t_stream();
    logic [7:0]  pa;
    logic [7:0]  ps;
    logic [15:0] po;
    bit          pn;
    @(negedge clk);
    pn = 1'b0; pa = 8'h00; ps = 8'h00; po = 16'h9406;
    drive(1'b1, po, pa, ps);
    for (int i = 1; i < 512; i++) begin
      @(negedge clk);
      chk("R9", "stream result", {8'd0, result}, {8'd0, m_res(pn, pa)});
      chk("R9", "stream status", {8'd0, status_out}, {8'd0, m_stat(pn, pa, ps)});
      pn = i[0];
      pa = i[8:1];
      ps = 8'(i * 37);
      po = pn ? {7'b1001010, i[5:1], 4'h1} : {7'b1001010, i[5:1], 4'h6};
      drive(1'b1, po, pa, ps);
    end
    @(negedge clk);
    chk("R9", "stream last", {8'd0, status_out}, {8'd0, m_stat(pn, pa, ps)});
    drive(1'b0, 16'h0000, 8'h00, 8'h00);
  endtask

  initial begin
    rst = 1'b1;
    drive(1'b0, 16'h0000, 8'h00, 8'h00);
    t_reset();
    t_lsr_known();
    t_lsr_zero();
    t_lsr_keep_h();
    t_neg_known();
    t_neg_zero();
    t_neg_min();
    t_unsupported();
    t_stream();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule